// File: doc/BRIEF.md
# Telecommand Receive Buffer

A register-mapped receive buffer for command frames that arrive on an external link. The link side pushes bytes, one per cycle, through a side write port. The processor takes them out one at a time by reading a data register on a 32-bit register interface.

The block keeps a status byte with four hardware flags: empty, half-full, full and frame-complete. It also keeps a 16-bit count of completed frames, a count of the bytes it holds, and a soft-reset register that acts on one key value. The link marks the end of a frame by OR-writing the frame-complete flag into the status byte. That write also advances the frame counter. Every new byte pushed clears the flag again. The interrupt output is held inactive.

Reads return data in the same cycle (combinational read data). A read of the data register removes the byte at the clock edge that ends the access. Only the low byte of the write data is significant.

Top module: `tc_rx_buffer`

## Requirements
- R1: After reset the status byte (offset 0x04), the held-byte count (offset 0x0C), the frame count (offset 0x1C) and the reset register (offset 0x7C) all read 0.
- R2: The buffer holds up to DEPTH (default 1024) bytes. Reads of offset 0x00 return the pushed bytes in push order, and offset 0x0C returns the number held.
- R3: A read of offset 0x00 while the buffer is empty returns 0 and leaves the buffer and its count unchanged.
- R4: Status bit 0 (empty) becomes 1 when a pop leaves the buffer empty, and becomes 0 when a push is stored.
- R5: A push while DEPTH bytes are held, with no pop in the same cycle, is dropped and sets status bit 2 (full). A pop clears bit 2. A push and a pop in the same cycle at full are both carried out.
- R6: Status bit 1 (half-full) reads 1 exactly when at least DEPTH/2 bytes are held. Writes have no effect on it.
- R7: Every push, whether stored or dropped, clears status bit 3 (frame complete), unless a status write in the same cycle sets it.
- R8: A write to offset 0x04 ORs the written byte into status bits 7..2 and 0. When bit 3 of the written byte is 1, the frame count advances by one, wrapping at 16 bits.
- R9: A write to offset 0x7C whose low byte is 0x55 empties the buffer and clears the status byte, the frame count and the reset register. Any other value is stored, reads back at 0x7C, and has no other effect.
- R10: Reads of offsets other than 0x00, 0x04, 0x0C, 0x1C and 0x7C return 0, writes to them change nothing, and the interrupt output is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 7 | Byte offset of the register |
| busWdata | input | 8 | Write data (low byte of the bus word) |
| busRdata | output | 32 | Read data, valid in the access cycle |
| pushValid | input | 1 | Link pushes a byte this cycle |
| pushByte | input | 8 | Byte from the link |
| irqOut | output | 1 | Interrupt, held at 0 |

## Verification
The hardest situation to reach from the ports is a push that arrives at a completely full buffer: with or without a pop in the same cycle, and also the half-full boundary one byte either side. Random traffic hovers near empty and never gets there. The bench therefore fills the buffer byte by byte in a directed phase, checks the status at 511 and 512 bytes held, overflows it, and then issues a push and a data read together. Frame count wrap-around is reached by a long run of 65536 frame-complete writes.

// File: rtl/tcrx_pkg.sv
package tcrx_pkg;

  localparam logic [6:0] OFS_DATA  = 7'h00;
  localparam logic [6:0] OFS_STAT  = 7'h04;
  localparam logic [6:0] OFS_COUNT = 7'h0C;
  localparam logic [6:0] OFS_FRAME = 7'h1C;
  localparam logic [6:0] OFS_RESET = 7'h7C;

  typedef enum logic [2:0] {
    RD_NONE, RD_DATA, RD_STAT, RD_COUNT, RD_FRAME, RD_RESET
  } rdSel_e;

  typedef struct packed {
    logic pop;        // remove head byte
    logic pushSeen;   // a push arrived (stored or dropped)
    logic pushOk;     // push is stored
    logic drop;       // push is dropped, buffer full
    logic statusWr;   // OR-write into the status byte
    logic softReset;  // key value written to reset register
    logic resetWr;    // store into reset register
  } strobes_t;

endpackage

// File: rtl/tcrx_ctrl.sv
module tcrx_ctrl
  import tcrx_pkg::*;
#(
  parameter logic [7:0] RESET_KEY = 8'h55
) (
  input  logic       busSel,
  input  logic       busWrite,
  input  logic [6:0] busAddr,
  input  logic [7:0] busWdata,
  input  logic       pushValid,
  input  logic       fifoEmpty,
  input  logic       fifoFull,
  output strobes_t   strobes,
  output rdSel_e     rdSel
);

  logic isRead;
  logic isWrite;

  assign isRead  = busSel && !busWrite;
  assign isWrite = busSel && busWrite;

  always_comb begin
    strobes           = '0;
    strobes.softReset = isWrite && (busAddr == OFS_RESET) && (busWdata == RESET_KEY);
    strobes.resetWr   = isWrite && (busAddr == OFS_RESET);
    strobes.statusWr  = isWrite && (busAddr == OFS_STAT);
    strobes.pop       = isRead && (busAddr == OFS_DATA) && !fifoEmpty;
    strobes.pushSeen  = pushValid && !strobes.softReset;
    strobes.pushOk    = strobes.pushSeen && (!fifoFull || strobes.pop);
    strobes.drop      = strobes.pushSeen && fifoFull && !strobes.pop;
  end

  always_comb begin
    rdSel = RD_NONE;
    if (isRead) begin
      unique case (busAddr)
        OFS_DATA:  rdSel = RD_DATA;
        OFS_STAT:  rdSel = RD_STAT;
        OFS_COUNT: rdSel = RD_COUNT;
        OFS_FRAME: rdSel = RD_FRAME;
        OFS_RESET: rdSel = RD_RESET;
        default:   rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/tcrx_datapath.sv
module tcrx_datapath
  import tcrx_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int FRAME_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobes_t    strobes,
  input  rdSel_e      rdSel,
  input  logic [7:0]  busWdata,
  input  logic [7:0]  pushByte,
  output logic        fifoEmpty,
  output logic        fifoFull,
  output logic [31:0] rdData
);

  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int HALF = DEPTH / 2;

  logic [7:0]         mem [DEPTH];
  logic [AW-1:0]      wrPtr;
  logic [AW-1:0]      rdPtr;
  logic [CW-1:0]      count;
  logic [7:0]         statusReg;
  logic [7:0]         statusNext;
  logic [FRAME_W-1:0] frameCnt;
  logic [7:0]         resetReg;
  logic               halfFull;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CW'(DEPTH));
  assign halfFull  = (count >= CW'(HALF));

  // status byte update; later lines take priority
  always_comb begin
    statusNext = statusReg;
    if (strobes.pushOk) statusNext[0] = 1'b0;
    else if (strobes.pop && count == CW'(1)) statusNext[0] = 1'b1;
    if (strobes.drop) statusNext[2] = 1'b1;
    if (strobes.pop)  statusNext[2] = 1'b0;
    if (strobes.pushSeen) statusNext[3] = 1'b0;
    if (strobes.statusWr) statusNext = statusNext | (busWdata & 8'hFD);
    statusNext[1] = 1'b0;  // half-full is live, never stored
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      statusReg <= '0;
      frameCnt  <= '0;
      resetReg  <= '0;
    end else if (strobes.softReset) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      statusReg <= '0;
      frameCnt  <= '0;
      resetReg  <= '0;
    end else begin
      if (strobes.pushOk) wrPtr <= wrPtr + 1'b1;
      if (strobes.pop)    rdPtr <= rdPtr + 1'b1;
      unique case ({strobes.pushOk, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      statusReg <= statusNext;
      if (strobes.statusWr && busWdata[3]) frameCnt <= frameCnt + 1'b1;
      if (strobes.resetWr) resetReg <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.pushOk) mem[wrPtr] <= pushByte;
  end

  always_comb begin
    unique case (rdSel)
      RD_DATA:  rdData = fifoEmpty ? 32'd0 : {24'd0, mem[rdPtr]};
      RD_STAT:  rdData = {24'd0, statusReg[7:2], halfFull, statusReg[0]};
      RD_COUNT: rdData = 32'(count);
      RD_FRAME: rdData = 32'(frameCnt);
      RD_RESET: rdData = {24'd0, resetReg};
      default:  rdData = 32'd0;
    endcase
  end

  // R2: the held count never exceeds capacity
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R3: control never pops an empty buffer
  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> count != '0);

  // R4: popping the last byte raises the empty flag
  p_last_pop_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pop && count == CW'(1) && !strobes.pushOk) |=> statusReg[0]);

  // R5: a dropped push leaves the buffer full with the full flag set
  p_drop_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.drop |=> (statusReg[2] && count == CW'(DEPTH)));

  // R7: a push clears frame-complete unless a status write sets it again
  p_push_clears_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pushSeen && !strobes.statusWr) |=> !statusReg[3]);

  // R8: frame-complete written advances the frame count by one
  p_frame_inc_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.statusWr && busWdata[3]) |=> frameCnt == FRAME_W'($past(frameCnt) + 1'b1));

  // R9: the key value clears everything
  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.softReset |=> (count == '0 && statusReg == '0 && frameCnt == '0 && resetReg == '0));

endmodule

// File: rtl/tc_rx_buffer.sv
module tc_rx_buffer
  import tcrx_pkg::*;
#(
  parameter int         DEPTH     = 1024,
  parameter int         FRAME_W   = 16,
  parameter logic [7:0] RESET_KEY = 8'h55
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [6:0]  busAddr,
  input  logic [7:0]  busWdata,
  output logic [31:0] busRdata,
  input  logic        pushValid,
  input  logic [7:0]  pushByte,
  output logic        irqOut
);

  strobes_t strobes;
  rdSel_e   rdSel;
  logic     fifoEmpty;
  logic     fifoFull;

  tcrx_ctrl #(
    .RESET_KEY(RESET_KEY)
  ) i_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .pushValid(pushValid),
    .fifoEmpty(fifoEmpty),
    .fifoFull (fifoFull),
    .strobes  (strobes),
    .rdSel    (rdSel)
  );

  tcrx_datapath #(
    .DEPTH  (DEPTH),
    .FRAME_W(FRAME_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .pushByte (pushByte),
    .fifoEmpty(fifoEmpty),
    .fifoFull (fifoFull),
    .rdData   (busRdata)
  );

  assign irqOut = 1'b0;  // R10

endmodule

// File: tb/test_tc_rx_buffer.sv
module test_tc_rx_buffer;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [31:0] busRdata;
  logic        pushValid = 1'b0;
  logic [7:0]  pushByte = '0;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;

  // bench model
  logic [7:0]  q[$];
  logic [7:0]  mStat = '0;
  logic [15:0] mFrame = '0;
  logic [7:0]  mRst = '0;

  always #5 clk = ~clk;

  tc_rx_buffer i_tc_rx_buffer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pushValid(pushValid), .pushByte(pushByte), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [6:0] a);
    case (a)
      7'h00:   return (q.size() > 0) ? {24'd0, q[0]} : 32'd0;
      7'h04:   return {24'd0, mStat[7:2], (q.size() >= DEPTH / 2), mStat[0]};
      7'h0C:   return 32'(q.size());
      7'h1C:   return {16'd0, mFrame};
      7'h7C:   return {24'd0, mRst};
      default: return 32'd0;
    endcase
  endfunction

  function automatic void modelStep(input logic pv, input logic [7:0] pb, input logic sel,
                                    input logic wr, input logic [6:0] a, input logic [7:0] wd);
    logic popOk;
    logic pushIn;
    if (sel && wr && a == 7'h7C && wd == 8'h55) begin
      q.delete(); mStat = '0; mFrame = '0; mRst = '0;
      return;
    end
    popOk  = sel && !wr && a == 7'h00 && q.size() > 0;
    pushIn = pv && (q.size() < DEPTH || popOk);
    if (popOk) begin
      void'(q.pop_front());
      mStat[2] = 1'b0;
    end
    if (pushIn) begin
      q.push_back(pb);
      mStat[0] = 1'b0;
    end else if (popOk && q.size() == 0) begin
      mStat[0] = 1'b1;
    end
    if (pv && !pushIn) mStat[2] = 1'b1;
    if (pv) mStat[3] = 1'b0;
    if (sel && wr && a == 7'h04) begin
      mStat = mStat | (wd & 8'hFD);
      if (wd[3]) mFrame = mFrame + 16'd1;
    end
    if (sel && wr && a == 7'h7C) mRst = wd;
    mStat[1] = 1'b0;
  endfunction

  // one bus/push cycle; reads are compared with the model
  task automatic busOp(input string tag, input logic pv, input logic [7:0] pb,
                       input logic sel, input logic wr, input logic [6:0] a,
                       input logic [7:0] wd);
    logic [31:0] exp;
    @(negedge clk);
    pushValid = pv; pushByte = pb; busSel = sel; busWrite = wr; busAddr = a; busWdata = wd;
    exp = expRead(a);
    #4;
    if (sel && !wr) check(tag, busRdata, exp);
    modelStep(pv, pb, sel, wr, a, wd);
    @(posedge clk);
    #1;
    pushValid = 1'b0; busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [6:0] a);
    busOp(tag, 1'b0, 8'h00, 1'b1, 1'b0, a, 8'h00);
  endtask

  task automatic wrReg(input logic [6:0] a, input logic [7:0] wd);
    busOp("write", 1'b0, 8'h00, 1'b1, 1'b1, a, wd);
  endtask

  task automatic push(input logic [7:0] b);
    busOp("push", 1'b1, b, 1'b0, 1'b0, 7'h00, 8'h00);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stimulus
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state, R10 undefined offset and interrupt
    rd("R1 status", 7'h04);
    rd("R1 count", 7'h0C);
    rd("R1 frame", 7'h1C);
    rd("R1 reset reg", 7'h7C);
    rd("R10 undefined read", 7'h08);
    check("R10 irq", {31'd0, irqOut}, 32'd0);

    // R3 pop on empty
    rd("R3 empty data", 7'h00);
    rd("R3 count after empty pop", 7'h0C);

    // R2 order, R4 empty flag
    push(8'hA1); push(8'hB2); push(8'hC3);
    rd("R2 count 3", 7'h0C);
    rd("R2 first", 7'h00);
    rd("R2 second", 7'h00);
    rd("R4 empty clear", 7'h04);
    rd("R2 third", 7'h00);
    rd("R4 empty set", 7'h04);
    push(8'h5A);
    rd("R4 empty clear after push", 7'h04);

    // R8 OR-write and frame counter, R7 push clears frame-complete
    wrReg(7'h04, 8'h08);
    rd("R8 frame 1", 7'h1C);
    rd("R8 status done", 7'h04);
    push(8'h11);
    rd("R7 done cleared", 7'h04);
    wrReg(7'h04, 8'h32);
    rd("R8 OR bits, bit1 ignored", 7'h04);
    rd("R8 frame unchanged", 7'h1C);
    busOp("R7 push with done write", 1'b1, 8'h22, 1'b1, 1'b1, 7'h04, 8'h08);
    rd("R7 write wins", 7'h04);

    // R10 write to undefined offset
    wrReg(7'h08, 8'hFF);
    rd("R10 undefined after write", 7'h08);
    rd("R10 status unchanged", 7'h04);
    rd("R10 count unchanged", 7'h0C);

    // R9 non-key value is stored only
    wrReg(7'h7C, 8'hAA);
    rd("R9 stored", 7'h7C);
    rd("R9 count kept", 7'h0C);
    rd("R9 frame kept", 7'h1C);

    // R9 key clears everything
    wrReg(7'h7C, 8'h55);
    rd("R9 status cleared", 7'h04);
    rd("R9 count cleared", 7'h0C);
    rd("R9 frame cleared", 7'h1C);
    rd("R9 reg cleared", 7'h7C);
    rd("R9 data empty", 7'h00);

    // R6 half-full boundary, R5 full and overflow
    for (int i = 0; i < DEPTH / 2 - 1; i++) push(8'(i));
    rd("R6 below half", 7'h04);
    push(8'hEE);
    rd("R6 at half", 7'h04);
    while (q.size() < DEPTH) push(8'($urandom));
    rd("R2 full count", 7'h0C);
    rd("R5 full flag before overflow", 7'h04);
    push(8'h99);
    rd("R5 dropped count", 7'h0C);
    rd("R5 full flag set", 7'h04);
    busOp("R5 push+pop at full", 1'b1, 8'h77, 1'b1, 1'b0, 7'h00, 8'h00);
    rd("R5 count still full", 7'h0C);
    rd("R5 full flag cleared", 7'h04);
    for (int i = 0; i < 40; i++) rd("R2 drain order", 7'h00);
    rd("R6 still half", 7'h04);
    wrReg(7'h7C, 8'h55);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = int'($urandom % 9);
      case (sel)
        0, 1:    push(8'($urandom));
        2:       rd("R2 random data", 7'h00);
        3:       rd("R4 random status", 7'h04);
        4:       rd("R2 random count", 7'h0C);
        5:       wrReg(7'h04, 8'($urandom));
        6:       busOp("R2 random push+pop", 1'b1, 8'($urandom), 1'b1, 1'b0, 7'h00, 8'h00);
        7:       rd("R8 random frame", 7'h1C);
        default: begin
          wrReg(7'h7C, ($urandom % 16 == 0) ? 8'h55 : 8'($urandom));
          rd("R9 random reset reg", 7'h7C);
        end
      endcase
    end

    // R8 16-bit wrap
    rd("R8 frame before wrap", 7'h1C);
    for (int i = 0; i < 65536; i++) wrReg(7'h04, 8'h08);
    rd("R8 frame after wrap", 7'h1C);
    check("R10 irq at end", {31'd0, irqOut}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule